// File: doc/BRIEF.md
# Infrared Asynchronous Frame Receiver

This block sits behind the character receiver of a slow-rate infrared serial link. It takes one 8-bit character per `rx_valid` strobe and rebuilds frames from the stream. A frame opens with the character 0xC0 and closes with 0xC1. The character 0x7D marks the next character as escaped. The payload bytes, followed by the two trailing frame check bytes, go into the buffer of the current receive descriptor at rising offsets. When the frame closes, a status word and a length go back into that descriptor.

The descriptors form a ring that software owns and refills. A descriptor carries an empty bit, which means software has handed it to hardware, and a wrap bit, which closes the ring early. The block reads both bits through a small read port. It writes the completed status and length through a write port. After every N completed descriptors it raises a one-cycle event, where N comes from a threshold input.

A three-state machine controls reception:
- HUNT waits for 0xC0 and ignores every other character.
- BODY stores characters. 0xC0 restarts the frame and 0xC1 closes it. 0x7D moves to ESCAPED.
- ESCAPED stores the next character XOR 0x20 and returns to BODY. A 0xC0 here restarts the frame in BODY. A 0xC1 here closes the frame as aborted and returns to HUNT.

Top module: `sir_rx_deframer`

## Requirements
- R1: After reset no buffer write, descriptor write or event is issued, and `desc_rd_idx` is 0.
- R2: In HUNT, every character other than 0xC0 is ignored, including a stray 0xC1 or 0x7D. Such characters cause no buffer or descriptor write.
- R3: Characters received between 0xC0 and 0xC1 are written in order at buffer offsets 0, 1, 2 and so on. The reported length counts every stored byte, including the two frame check bytes.
- R4: The character 0x7D is dropped. The character after it is stored as its value XOR 0x20.
- R5: The frame check runs over every stored byte. It uses a 16-bit remainder preset to 0xFFFF, a reflected polynomial 0x8408, and least significant bit first. A frame is good only if the final remainder is 0xF0B8. Otherwise status bit 2 (CRC error) is set.
- R6: At the close of a frame the written status has the following content:
  - bit 15 (empty) is cleared;
  - bit 13 (wrap) is copied from the descriptor;
  - bits 3, 2 and 1 are error bits, with at most one of them set;
  - every other bit is 0.
- R7: After a descriptor is written, the ring index moves to 0 if the wrap bit was set or the entry was the last one. Otherwise it moves to the next entry.
- R8: A 0xC0 inside a frame restarts the frame. Storage begins again at offset 0, and the frame check is preset again.
- R9: A 0x7D followed directly by 0xC1 closes the frame with status bit 3 (abort) set.
- R10: Stored bytes beyond `BUF_BYTES` are dropped, the length is capped at `BUF_BYTES`, and status bit 1 (overrun) is set. Error priority is abort first, then overrun, then CRC error.
- R11: If the descriptor is not empty when 0xC0 arrives, the frame makes no buffer writes. At the close, the descriptor is written with the overrun bit if it has become empty by then. If it is still not empty, the frame is discarded and the index does not move.
- R12: `frame_evt` pulses for one cycle together with the descriptor write that completes the Nth frame since the last event. N is `evt_thresh`, and a value of 0 or 1 means every frame.
- R13: A buffer write or descriptor write appears on the outputs in the cycle after the cycle in which the causing character is strobed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | Character strobe |
| rx_data | input | 8 | Received character |
| evt_thresh | input | THR_W | Frames per event (0 acts as 1) |
| desc_rd_idx | output | IDX_W | Index of the current descriptor |
| desc_rd_empty | input | 1 | Empty bit of the current descriptor |
| desc_rd_wrap | input | 1 | Wrap bit of the current descriptor |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_desc | output | IDX_W | Descriptor whose buffer is written |
| buf_addr | output | ADDR_W | Byte offset in that buffer |
| buf_data | output | 8 | Byte written |
| desc_we | output | 1 | Descriptor write strobe |
| desc_wr_idx | output | IDX_W | Descriptor written |
| desc_wr_stat | output | 16 | Status word written |
| desc_wr_len | output | LEN_W | Stored frame length |
| frame_evt | output | 1 | Frame-received event pulse |

## Verification
A plain payload checks byte order, the length rule and a good frame check. A payload that contains all three special values shows that escaping is undone before storage and before the frame check. A frame with one flipped check bit must give only the CRC error bit. A restart, an escape followed by the close character, and an oversized frame each give one different error bit or offset pattern. A descriptor that software has not handed back, in one case returned before the frame closes and in one case never returned, separates the write-with-overrun outcome from the silent discard. Threshold values 3 and 0 separate counted events from per-frame events.

// File: rtl/sir_rx_pkg.sv
package sir_rx_pkg;
    localparam logic [7:0]  CH_BOF      = 8'hC0;
    localparam logic [7:0]  CH_EOF      = 8'hC1;
    localparam logic [7:0]  CH_ESC      = 8'h7D;
    localparam logic [7:0]  ESC_FLIP    = 8'h20;
    localparam logic [15:0] FCS_INIT    = 16'hFFFF;
    localparam logic [15:0] FCS_RESIDUE = 16'hF0B8;
    localparam logic [15:0] FCS_POLY    = 16'h8408;

    localparam int ST_EMPTY   = 15;
    localparam int ST_WRAP    = 13;
    localparam int ST_ABORT   = 3;
    localparam int ST_CRCERR  = 2;
    localparam int ST_OVERRUN = 1;

    typedef enum logic [1:0] {
        S_HUNT    = 2'd0,
        S_BODY    = 2'd1,
        S_ESCAPED = 2'd2
    } rx_state_e;

    // One byte of the reflected 16-bit check, LSB first.
    function automatic logic [15:0] fcs_next(input logic [15:0] cur, input logic [7:0] din);
        logic [15:0] c;
        c = cur;
        for (int i = 0; i < 8; i++) begin
            if (c[0] ^ din[i]) c = (c >> 1) ^ FCS_POLY;
            else               c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/sir_fcs16.sv
module sir_fcs16 import sir_rx_pkg::*; (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        upd,
    input  logic [7:0]  din,
    output logic [15:0] fcs_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   fcs_q <= FCS_INIT;
        else if (clr) fcs_q <= FCS_INIT;
        else if (upd) fcs_q <= fcs_next(fcs_q, din);
    end

    // R8
    fcs_preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (fcs_q == FCS_INIT));
endmodule

// File: rtl/sir_ring_ptr.sv
module sir_ring_ptr #(
    parameter  int NUM_DESC = 4,
    localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             wrap,
    output logic [IDX_W-1:0] idx_q
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_DESC - 1);

    logic last_or_wrap;
    assign last_or_wrap = wrap || (idx_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   idx_q <= '0;
        else if (adv) idx_q <= last_or_wrap ? '0 : idx_q + IDX_W'(1);
    end

    // R7
    ring_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(idx_q));
endmodule

// File: rtl/sir_evt_count.sv
module sir_evt_count #(
    parameter int THR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_done,
    input  logic [THR_W-1:0] thresh,
    output logic             evt_q
);
    logic [THR_W-1:0] cnt_q;
    logic [THR_W-1:0] eff;
    logic             hit;

    assign eff = (thresh == '0) ? THR_W'(1) : thresh;
    assign hit = ({1'b0, cnt_q} + (THR_W+1)'(1)) >= {1'b0, eff};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt_q <= 1'b0;
        end else begin
            evt_q <= frame_done && hit;
            if (frame_done) cnt_q <= hit ? '0 : cnt_q + THR_W'(1);
        end
    end

    // R12
    evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> $past(frame_done));
endmodule

// File: rtl/sir_rx_deframer.sv
module sir_rx_deframer import sir_rx_pkg::*; #(
    parameter  int NUM_DESC  = 4,
    parameter  int BUF_BYTES = 16,
    parameter  int THR_W     = 4,
    localparam int IDX_W     = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1,
    localparam int ADDR_W    = (BUF_BYTES > 1) ? $clog2(BUF_BYTES) : 1,
    localparam int LEN_W     = $clog2(BUF_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    input  logic [THR_W-1:0]  evt_thresh,
    output logic [IDX_W-1:0]  desc_rd_idx,
    input  logic              desc_rd_empty,
    input  logic              desc_rd_wrap,
    output logic              buf_we,
    output logic [IDX_W-1:0]  buf_desc,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_data,
    output logic              desc_we,
    output logic [IDX_W-1:0]  desc_wr_idx,
    output logic [15:0]       desc_wr_stat,
    output logic [LEN_W-1:0]  desc_wr_len,
    output logic              frame_evt
);
    localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_BYTES);

    rx_state_e        state_q, state_d;
    logic             start, store, close, abort_close;
    logic [7:0]       store_byte;
    logic [LEN_W-1:0] cnt_q;
    logic             ovr_q, skip_q, full;
    logic [15:0]      fcs_q;
    logic [15:0]      stat_d;
    logic             done;
    logic [IDX_W-1:0] ring_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HUNT;
        else        state_q <= state_d;
    end

    // next state and frame actions
    always_comb begin
        state_d     = state_q;
        start       = 1'b0;
        store       = 1'b0;
        close       = 1'b0;
        abort_close = 1'b0;
        store_byte  = rx_data;
        if (rx_valid) begin
            unique case (state_q)
                S_HUNT: begin
                    if (rx_data == CH_BOF) begin
                        start   = 1'b1;
                        state_d = S_BODY;
                    end
                end
                S_BODY: begin
                    if (rx_data == CH_BOF) begin
                        start = 1'b1;
                    end else if (rx_data == CH_EOF) begin
                        close   = 1'b1;
                        state_d = S_HUNT;
                    end else if (rx_data == CH_ESC) begin
                        state_d = S_ESCAPED;
                    end else begin
                        store = 1'b1;
                    end
                end
                S_ESCAPED: begin
                    if (rx_data == CH_BOF) begin
                        start   = 1'b1;
                        state_d = S_BODY;
                    end else if (rx_data == CH_EOF) begin
                        close       = 1'b1;
                        abort_close = 1'b1;
                        state_d     = S_HUNT;
                    end else begin
                        store      = 1'b1;
                        store_byte = rx_data ^ ESC_FLIP;
                        state_d    = S_BODY;
                    end
                end
                default: state_d = S_HUNT;
            endcase
        end
    end

    assign full = (cnt_q >= CAP);

    // frame length, overrun and ownership tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            ovr_q  <= 1'b0;
            skip_q <= 1'b0;
        end else if (start) begin
            cnt_q  <= '0;
            ovr_q  <= !desc_rd_empty;
            skip_q <= !desc_rd_empty;
        end else if (store) begin
            if (!full) cnt_q <= cnt_q + LEN_W'(1);
            else       ovr_q <= 1'b1;
        end
    end

    sir_fcs16 u_fcs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .upd   (store),
        .din   (store_byte),
        .fcs_q (fcs_q)
    );

    assign done = close && desc_rd_empty;

    sir_ring_ptr #(.NUM_DESC(NUM_DESC)) u_ring (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (done),
        .wrap  (desc_rd_wrap),
        .idx_q (ring_idx)
    );

    sir_evt_count #(.THR_W(THR_W)) u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (done),
        .thresh     (evt_thresh),
        .evt_q      (frame_evt)
    );

    always_comb begin
        stat_d             = '0;
        stat_d[ST_WRAP]    = desc_rd_wrap;
        stat_d[ST_ABORT]   = abort_close;
        stat_d[ST_OVERRUN] = !abort_close && ovr_q;
        stat_d[ST_CRCERR]  = !abort_close && !ovr_q && (fcs_q != FCS_RESIDUE);
    end

    // registered output stage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_we       <= 1'b0;
            buf_desc     <= '0;
            buf_addr     <= '0;
            buf_data     <= '0;
            desc_we      <= 1'b0;
            desc_wr_idx  <= '0;
            desc_wr_stat <= '0;
            desc_wr_len  <= '0;
        end else begin
            buf_we       <= store && !skip_q && !full;
            buf_desc     <= ring_idx;
            buf_addr     <= cnt_q[ADDR_W-1:0];
            buf_data     <= store_byte;
            desc_we      <= done;
            desc_wr_idx  <= ring_idx;
            desc_wr_stat <= stat_d;
            desc_wr_len  <= cnt_q;
        end
    end

    assign desc_rd_idx = ring_idx;

    // R2
    hunt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_HUNT) |=> !buf_we);

    // R6
    desc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> !desc_wr_stat[ST_EMPTY]);

    // R10
    err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> $onehot0(desc_wr_stat[ST_ABORT:ST_OVERRUN]));

    // R11
    owned_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        buf_we |-> !$past(skip_q));

    // R13
    write_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_we || desc_we) |-> $past(rx_valid));

    // R3
    no_dual_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_we && desc_we));
endmodule

// File: tb/sir_rx_deframer_test.sv
module sir_rx_deframer_test;
    localparam int NUM_DESC  = 4;
    localparam int BUF_BYTES = 16;
    localparam int THR_W     = 4;
    localparam int IDX_W     = 2;
    localparam int ADDR_W    = 4;
    localparam int LEN_W     = 5;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              rx_valid = 1'b0;
    logic [7:0]        rx_data = '0;
    logic [THR_W-1:0]  evt_thresh = THR_W'(1);
    logic [IDX_W-1:0]  desc_rd_idx;
    logic              desc_rd_empty, desc_rd_wrap;
    logic              buf_we;
    logic [IDX_W-1:0]  buf_desc;
    logic [ADDR_W-1:0] buf_addr;
    logic [7:0]        buf_data;
    logic              desc_we;
    logic [IDX_W-1:0]  desc_wr_idx;
    logic [15:0]       desc_wr_stat;
    logic [LEN_W-1:0]  desc_wr_len;
    logic              frame_evt;

    logic [15:0] mem_stat [0:NUM_DESC-1];
    logic [LEN_W-1:0] mem_len [0:NUM_DESC-1];
    logic [7:0]  cap [0:NUM_DESC-1][0:BUF_BYTES-1];
    logic [7:0]  pl [0:31];
    logic [7:0]  ex [0:33];

    int n_chk = 0, n_bad = 0;
    int n_bufwr = 0, n_descwr = 0, n_evt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    assign desc_rd_empty = mem_stat[desc_rd_idx][15];
    assign desc_rd_wrap  = mem_stat[desc_rd_idx][13];

    sir_rx_deframer #(.NUM_DESC(NUM_DESC), .BUF_BYTES(BUF_BYTES), .THR_W(THR_W)) uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .evt_thresh(evt_thresh), .desc_rd_idx(desc_rd_idx),
        .desc_rd_empty(desc_rd_empty), .desc_rd_wrap(desc_rd_wrap),
        .buf_we(buf_we), .buf_desc(buf_desc), .buf_addr(buf_addr), .buf_data(buf_data),
        .desc_we(desc_we), .desc_wr_idx(desc_wr_idx), .desc_wr_stat(desc_wr_stat),
        .desc_wr_len(desc_wr_len), .frame_evt(frame_evt)
    );

    // memory model and event counting, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we) begin
                cap[buf_desc][buf_addr] = buf_data;
                n_bufwr++;
            end
            if (desc_we) begin
                mem_stat[desc_wr_idx] = desc_wr_stat;
                mem_len[desc_wr_idx]  = desc_wr_len;
                n_descwr++;
            end
            if (frame_evt) n_evt++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c;
        for (int k = 0; k < 8; k++) begin
            logic fb;
            fb = r[0] ^ b[k];
            r  = {1'b0, r[15:1]};
            if (fb) r = r ^ 16'h8408;
        end
        return r;
    endfunction

    task automatic idle(input int k);
        repeat (k) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_data  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
        rx_data  = '0;
    endtask

    task automatic send_esc(input logic [7:0] b);
        if (b == 8'hC0 || b == 8'hC1 || b == 8'h7D) begin
            send_byte(8'h7D);
            send_byte(b ^ 8'h20);
        end else begin
            send_byte(b);
        end
    endtask

    task automatic prep(input int n, input bit bad);
        logic [15:0] c;
        c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            c = ref_crc(c, pl[i]);
            ex[i] = pl[i];
        end
        c = ~c;
        if (bad) c[0] = ~c[0];
        ex[n]   = c[7:0];
        ex[n+1] = c[15:8];
    endtask

    task automatic send_raw(input int from, input int upto);
        for (int i = from; i < upto; i++) send_esc(ex[i]);
    endtask

    task automatic clear_cap(input int d);
        for (int i = 0; i < BUF_BYTES; i++) cap[d][i] = 8'h00;
    endtask

    task automatic send_frame(input int n, input bit bad);
        prep(n, bad);
        send_byte(8'hC0);
        send_raw(0, n + 2);
        send_byte(8'hC1);
        idle(2);
    endtask

    task automatic chk_buf(input string req, input int d, input int n);
        for (int i = 0; i < n; i++) chk(req, cap[d][i], ex[i]);
    endtask

    task automatic test_reset();
        chk("R1 rd_idx", desc_rd_idx, 0);
        chk("R1 buf_we", buf_we, 0);
        chk("R1 desc_we", desc_we, 0);
        chk("R1 frame_evt", frame_evt, 0);
    endtask

    task automatic test_idle_bytes();
        int b0, d0;
        b0 = n_bufwr; d0 = n_descwr;
        send_byte(8'h11); send_byte(8'hC1); send_byte(8'h7D);
        send_byte(8'h22); send_byte(8'hC1);
        idle(2);
        chk("R2 no buf writes", n_bufwr, b0);
        chk("R2 no desc writes", n_descwr, d0);
        chk("R2 index", desc_rd_idx, 0);
    endtask

    task automatic test_good();
        int e0;
        e0 = n_evt;
        clear_cap(0);
        pl[0] = 8'h01; pl[1] = 8'h02; pl[2] = 8'h03;
        prep(3, 0);
        send_byte(8'hC0);
        send_byte(ex[0]);
        chk("R13 buf_we lag", buf_we, 1);
        chk("R13 buf_addr", buf_addr, 0);
        chk("R13 buf_data", buf_data, 8'h01);
        send_raw(1, 5);
        send_byte(8'hC1);
        chk("R13 desc_we lag", desc_we, 1);
        chk("R12 evt with write", frame_evt, 1);
        idle(2);
        chk("R6 status good", mem_stat[0], 16'h0000);
        chk("R3 length incl fcs", mem_len[0], 5);
        chk_buf("R3 bytes", 0, 5);
        chk("R7 next index", desc_rd_idx, 1);
        chk("R12 one event", n_evt, e0 + 1);
    endtask

    task automatic test_escape();
        clear_cap(1);
        pl[0] = 8'hC0; pl[1] = 8'h7D; pl[2] = 8'hC1; pl[3] = 8'h41;
        send_frame(4, 0);
        chk("R4 R5 status good, wrap kept", mem_stat[1], 16'h2000);
        chk("R4 length", mem_len[1], 6);
        chk_buf("R4 unescaped bytes", 1, 6);
        chk("R7 wrap to 0", desc_rd_idx, 0);
        mem_stat[0] = 16'h8000;
    endtask

    task automatic test_badfcs();
        clear_cap(0);
        pl[0] = 8'h10; pl[1] = 8'h20; pl[2] = 8'h30; pl[3] = 8'h40; pl[4] = 8'h50;
        send_frame(5, 1);
        chk("R5 crc error bit", mem_stat[0], 16'h0004);
        chk("R5 length", mem_len[0], 7);
        chk("R7 index", desc_rd_idx, 1);
        mem_stat[1] = 16'h8000;
    endtask

    task automatic test_restart();
        clear_cap(1);
        send_byte(8'hC0); send_byte(8'hAA); send_byte(8'hBB);
        pl[0] = 8'h5A; pl[1] = 8'hA5;
        send_frame(2, 0);
        chk("R8 status good after restart", mem_stat[1], 16'h0000);
        chk("R8 length", mem_len[1], 4);
        chk_buf("R8 bytes from offset 0", 1, 4);
        chk("R7 index", desc_rd_idx, 2);
    endtask

    task automatic test_abort();
        send_byte(8'hC0); send_byte(8'h11); send_byte(8'h22);
        send_byte(8'h7D); send_byte(8'hC1);
        idle(2);
        chk("R9 abort bit", mem_stat[2], 16'h0008);
        chk("R9 length", mem_len[2], 2);
        chk("R7 index", desc_rd_idx, 3);
    endtask

    task automatic test_overrun();
        int b0;
        b0 = n_bufwr;
        clear_cap(3);
        for (int i = 0; i < 20; i++) pl[i] = 8'(i * 3 + 1);
        send_frame(20, 0);
        chk("R10 overrun bit", mem_stat[3], 16'h0002);
        chk("R10 length capped", mem_len[3], BUF_BYTES);
        chk("R10 write count", n_bufwr - b0, BUF_BYTES);
        chk_buf("R10 kept bytes", 3, BUF_BYTES);
        chk("R7 last entry to 0", desc_rd_idx, 0);
    endtask

    task automatic test_owned();
        int b0, d0;
        b0 = n_bufwr; d0 = n_descwr;
        send_byte(8'hC0); send_byte(8'h55); send_byte(8'h66); send_byte(8'hC1);
        idle(2);
        chk("R11 no buf writes", n_bufwr, b0);
        chk("R11 discarded", n_descwr, d0);
        chk("R11 index held", desc_rd_idx, 0);
        chk("R11 status untouched", mem_stat[0], 16'h0004);
        send_byte(8'hC0); send_byte(8'h77); send_byte(8'h88); send_byte(8'h99);
        mem_stat[0] = 16'h8000;
        send_byte(8'hC1);
        idle(2);
        chk("R11 written late", n_descwr, d0 + 1);
        chk("R11 still no buf writes", n_bufwr, b0);
        chk("R11 overrun bit", mem_stat[0], 16'h0002);
        chk("R11 length", mem_len[0], 3);
        chk("R11 index", desc_rd_idx, 1);
    endtask

    task automatic test_thresh();
        int e0;
        for (int d = 0; d < NUM_DESC; d++) mem_stat[d] = 16'h8000;
        evt_thresh = THR_W'(3);
        e0 = n_evt;
        pl[0] = 8'h33;
        send_frame(1, 0);
        chk("R12 thr3 frame1", n_evt, e0);
        send_frame(1, 0);
        chk("R12 thr3 frame2", n_evt, e0);
        send_frame(1, 0);
        chk("R12 thr3 frame3", n_evt, e0 + 1);
        send_frame(1, 0);
        chk("R12 thr3 frame4", n_evt, e0 + 1);
        evt_thresh = '0;
        mem_stat[1] = 16'h8000;
        send_frame(1, 0);
        chk("R12 thr0 every frame", n_evt, e0 + 2);
    endtask

    initial begin
        mem_stat[0] = 16'h8000;
        mem_stat[1] = 16'hA000;
        mem_stat[2] = 16'h8000;
        mem_stat[3] = 16'h8000;
        for (int d = 0; d < NUM_DESC; d++) begin
            mem_len[d] = '0;
            clear_cap(d);
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_idle_bytes();
        test_good();
        test_escape();
        test_badfcs();
        test_restart();
        test_abort();
        test_overrun();
        test_owned();
        test_thresh();
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=expired expected=done");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule